// File: doc/BRIEF.md
# Shadowed Configuration Register File

This block keeps nine byte-wide configuration registers for a temperature-control front end. Seven of them, at addresses 01h to 07h, exist twice: a working copy that drives the configuration fields, and a non-volatile backing copy that survives reset. Address 00h is a constant identity byte. Address 08h is a working-only control/status byte that holds the bank-select bit and the busy flag. After reset the block copies every backing byte into its working register, one address per cycle. It keeps the bus port out of use until that copy is complete.

A simple slave port carries byte writes, a STOP marker and combinational reads. The bank-select bit decides where a write goes. It either updates the working copy alone at once, or it is held as a pending non-volatile write. That pending write is committed by a self-timed program cycle that starts at the next STOP. While the program cycle runs, the busy flag is set and the port ignores new writes and STOPs. Reads stay available so that software can poll the flag. The non-volatile array is a behavioural model whose program time is a parameter counted in clock cycles.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is low and for the 7 cycles after it is released, `bus_ready` is 0. After that, each of 01h to 07h reads back its backing-copy value, and 08h reads 00h.
- R2: With a blank backing store, the values read after reset are 01h=03h, 02h=80h, 03h=90h, 04h=80h, 05h=00h, 06h=00h and 08h=00h.
- R3: When 08h bit 7 is 1, a write to 01h–06h changes the working copy at the next clock edge. It leaves the backing copy untouched, so the value is lost at the next reset.
- R4: When 08h bit 7 is 0, a write to 01h–06h is held as pending and the working copy keeps its old value. A later write replaces the pending byte. At the end of the program cycle the pending byte appears in both copies.
- R5: A STOP that arrives with a non-volatile write pending sets 08h bit 0 (busy) from the next cycle, for PROG_CYCLES cycles. Busy clears in the same cycle in which the committed byte becomes readable. `bus_ready` is 0 while busy is 1.
- R6: A STOP with no pending non-volatile write leaves busy at 0.
- R7: While busy is 1, writes and STOPs are ignored, and reads still return the working copy.
- R8: 00h always reads 00h. 07h reads the factory trim byte, with bit 7 as the sign and 1 meaning negative. Writes to 00h, to 07h and to addresses above 08h have no effect, and reads above 08h return 00h.
- R9: In 08h only bit 7 is writable. Bits 6:1 read 0 and bit 0 is busy. A write to 08h takes effect at once, whatever the bank selection.
- R10: The current-limit field is 01h[7:3], the coarse range is 01h[2:0], DAC enable is 03h[7], DAC gain is 03h[6], and loop gain is 03h[4:0].
- R11: When 03h[7] is 0, `cfg_dac_code` is 00h whatever 04h holds. Otherwise it equals 04h.
- R12: A committed non-volatile byte survives a reset and is recalled into the working copy. The bank-select bit resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 4 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_stop | input | 1 | One-cycle STOP marker from the bus front end |
| bus_raddr | input | 4 | Read address |
| bus_rdata | output | 8 | Read data, always from the working copy |
| bus_ready | output | 1 | Recall done and no program cycle running |
| cfg_ilim | output | 5 | Current-limit code |
| cfg_coarse | output | 3 | Coarse temperature range code |
| cfg_fine | output | 8 | Fine temperature code |
| cfg_dac_en | output | 1 | General-purpose DAC enable |
| cfg_dac_gain | output | 1 | General-purpose DAC gain select |
| cfg_loop_gain | output | 5 | Loop gain code |
| cfg_dac_code | output | 8 | DAC code, 00h when disabled |

## Verification
The bench builds the block with PROG_CYCLES set to 12 and TRIM_CODE set to F3h. The short program time lets the bench count the exact first and last busy cycles, and it leaves room to try a write and a STOP inside the busy window. The negative trim value exercises the sign bit of 07h. Two resets in one run show the difference between a committed byte, which is recalled, and a working-only byte, which is lost.

// File: rtl/srf_pkg.sv
// Shared constants for the shadowed register file.
// Assumes byte-wide registers and a 4-bit address space.
package srf_pkg;
    localparam int DW        = 8;
    localparam int AW        = 4;
    localparam int NV_WORDS  = 8;
    localparam int NV_AW     = $clog2(NV_WORDS);
    localparam logic [AW-1:0] CTRL_ADDR = 4'h8;
    localparam logic [AW-1:0] TRIM_ADDR = 4'h7;
    localparam logic [AW-1:0] LAST_RW   = 4'h6;
    localparam logic [DW-1:0] DEF_R1 = 8'h03;
    localparam logic [DW-1:0] DEF_R2 = 8'h80;
    localparam logic [DW-1:0] DEF_R3 = 8'h90;
    localparam logic [DW-1:0] DEF_R4 = 8'h80;
endpackage

// File: rtl/srf_nv_store.sv
// Behavioural non-volatile byte array. Holds factory content from time zero
// and keeps its content across rst_n, the way a real backing store would.
// Assumes at most one program write per cycle.
module srf_nv_store
    import srf_pkg::*;
#(
    parameter logic [DW-1:0] TRIM_CODE = 8'h00
) (
    input  logic             clk,
    input  logic             prog_we,
    input  logic [NV_AW-1:0] prog_addr,
    input  logic [DW-1:0]    prog_data,
    input  logic [NV_AW-1:0] rd_addr,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] cells [NV_WORDS] = '{8'h00, DEF_R1, DEF_R2, DEF_R3,
                                         DEF_R4, 8'h00, 8'h00, TRIM_CODE};

    // Program one byte when the sequencer commits.
    always_ff @(posedge clk) begin
        if (prog_we) cells[prog_addr] <= prog_data;
    end

    // Asynchronous read for the recall walk.
    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/srf_seq.sv
// Sequencer: walks the power-up recall, decodes bus writes by bank, holds
// one pending non-volatile byte, and times the program cycle after STOP.
// Assumes bus_stop is a single-cycle marker; produces one working-copy
// write port shared by recall, commit and direct writes (mutually exclusive).
module srf_seq
    import srf_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_stop,
    input  logic             bank_vol,
    input  logic [DW-1:0]    nv_rdata,
    output logic [NV_AW-1:0] nv_raddr,
    output logic             nv_we,
    output logic [NV_AW-1:0] nv_waddr,
    output logic [DW-1:0]    nv_wdata,
    output logic             vol_we,
    output logic [AW-1:0]    vol_addr,
    output logic [DW-1:0]    vol_data,
    output logic             recall_done,
    output logic             busy,
    output logic             ready
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [NV_AW-1:0] LAST_NV = NV_AW'(NV_WORDS - 1);

    logic [NV_AW-1:0] recall_idx;
    logic             pend_valid;
    logic [NV_AW-1:0] pend_addr;
    logic [DW-1:0]    pend_data;
    logic [CW-1:0]    cnt;
    logic             writable, accept, to_nv, commit;

    assign ready    = recall_done && !busy;
    assign writable = ((bus_addr >= 4'h1) && (bus_addr <= LAST_RW)) || (bus_addr == CTRL_ADDR);
    assign accept   = bus_wr && ready && writable;
    assign to_nv    = accept && (bus_addr != CTRL_ADDR) && !bank_vol;
    assign commit   = busy && (cnt == '0);

    // Power-up recall: one backing byte per cycle, 01h to 07h.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recall_idx  <= NV_AW'(1);
            recall_done <= 1'b0;
        end else if (!recall_done) begin
            if (recall_idx == LAST_NV) recall_done <= 1'b1;
            else                       recall_idx  <= recall_idx + 1'b1;
        end
    end

    // Pending byte capture, STOP-triggered start and program-time countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            busy       <= 1'b0;
            cnt        <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (ready) begin
            if (to_nv) begin
                pend_valid <= 1'b1;
                pend_addr  <= bus_addr[NV_AW-1:0];
                pend_data  <= bus_wdata;
            end
            if (bus_stop && (pend_valid || to_nv)) begin
                pend_valid <= 1'b0;
                busy       <= 1'b1;
                cnt        <= CW'(PROG_CYCLES - 1);
            end
        end
    end

    // Select the single working-copy write source.
    always_comb begin
        if (!recall_done) begin
            vol_we   = 1'b1;
            vol_addr = AW'(recall_idx);
            vol_data = nv_rdata;
        end else if (commit) begin
            vol_we   = 1'b1;
            vol_addr = AW'(pend_addr);
            vol_data = pend_data;
        end else begin
            vol_we   = accept && ((bus_addr == CTRL_ADDR) || bank_vol);
            vol_addr = bus_addr;
            vol_data = bus_wdata;
        end
    end

    assign nv_raddr = recall_idx;
    assign nv_we    = commit;
    assign nv_waddr = pend_addr;
    assign nv_wdata = pend_data;
endmodule

// File: rtl/srf_work_bank.sv
// Working (volatile) copy of 01h-07h plus the bank-select bit of 08h, and
// the read multiplexer. Assumes the sequencer already filtered writes.
module srf_work_bank
    import srf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          bank_vol,
    output logic [DW-1:0] reg1,
    output logic [DW-1:0] reg2,
    output logic [DW-1:0] reg3,
    output logic [DW-1:0] reg4
);
    logic [DW-1:0] work [1:NV_WORDS-1];

    // Working registers and the bank-select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NV_WORDS; i++) work[i] <= '0;
            bank_vol <= 1'b0;
        end else if (we) begin
            if (waddr == CTRL_ADDR)
                bank_vol <= wdata[DW-1];
            else if ((waddr != '0) && (waddr <= TRIM_ADDR))
                work[waddr[NV_AW-1:0]] <= wdata;
        end
    end

    // Read mux: reads never touch the backing copy.
    always_comb begin
        if (raddr == CTRL_ADDR)
            rdata = {bank_vol, {(DW-2){1'b0}}, busy};
        else if ((raddr != '0) && (raddr <= TRIM_ADDR))
            rdata = work[raddr[NV_AW-1:0]];
        else
            rdata = '0;
    end

    assign reg1 = work[1];
    assign reg2 = work[2];
    assign reg3 = work[3];
    assign reg4 = work[4];
endmodule

// File: rtl/shadow_regfile.sv
// Top of the shadowed register file: non-volatile store, sequencer and
// working bank, plus configuration field slicing for the analog side.
// Assumes a bus front end that delivers decoded byte writes and STOP markers.
module shadow_regfile
    import srf_pkg::*;
#(
    parameter int              PROG_CYCLES = 40,
    parameter logic [DW-1:0]   TRIM_CODE   = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_stop,
    input  logic [3:0] bus_raddr,
    output logic [7:0] bus_rdata,
    output logic       bus_ready,
    output logic [4:0] cfg_ilim,
    output logic [2:0] cfg_coarse,
    output logic [7:0] cfg_fine,
    output logic       cfg_dac_en,
    output logic       cfg_dac_gain,
    output logic [4:0] cfg_loop_gain,
    output logic [7:0] cfg_dac_code
);
    logic             bank_vol, busy, recall_done;
    logic [NV_AW-1:0] nv_raddr, nv_waddr;
    logic [DW-1:0]    nv_rdata, nv_wdata, vol_data;
    logic             nv_we, vol_we;
    logic [AW-1:0]    vol_addr;
    logic [DW-1:0]    reg1, reg2, reg3, reg4;

    srf_nv_store #(.TRIM_CODE(TRIM_CODE)) u_nv (
        .clk(clk), .prog_we(nv_we), .prog_addr(nv_waddr), .prog_data(nv_wdata),
        .rd_addr(nv_raddr), .rd_data(nv_rdata)
    );

    srf_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_stop(bus_stop), .bank_vol(bank_vol),
        .nv_rdata(nv_rdata), .nv_raddr(nv_raddr), .nv_we(nv_we),
        .nv_waddr(nv_waddr), .nv_wdata(nv_wdata), .vol_we(vol_we),
        .vol_addr(vol_addr), .vol_data(vol_data), .recall_done(recall_done),
        .busy(busy), .ready(bus_ready)
    );

    srf_work_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(vol_we), .waddr(vol_addr), .wdata(vol_data),
        .busy(busy), .raddr(bus_raddr), .rdata(bus_rdata), .bank_vol(bank_vol),
        .reg1(reg1), .reg2(reg2), .reg3(reg3), .reg4(reg4)
    );

    // Field slicing toward the analog circuits.
    assign cfg_ilim      = reg1[7:3];
    assign cfg_coarse    = reg1[2:0];
    assign cfg_fine      = reg2;
    assign cfg_dac_en    = reg3[7];
    assign cfg_dac_gain  = reg3[6];
    assign cfg_loop_gain = reg3[4:0];
    assign cfg_dac_code  = reg3[7] ? reg4 : 8'h00;
endmodule

// File: rtl/srf_checker.sv
// Temporal checks on the shadowed register file, attached by bind.
module srf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_stop,
    input logic       bus_ready,
    input logic       busy,
    input logic       bank_vol,
    input logic       recall_done,
    input logic [7:0] cfg_fine
);
    // R1
    recall_holds_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_done |-> !bus_ready);

    // R5
    busy_holds_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !bus_ready);

    // R5
    busy_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));

    // R3
    vol_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && bank_vol && bus_addr == 4'h2) |=> (cfg_fine == $past(bus_wdata)));

    // R7
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_fine));
endmodule

bind shadow_regfile srf_checker u_srf_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_stop(bus_stop), .bus_ready(bus_ready),
    .busy(busy), .bank_vol(bank_vol), .recall_done(recall_done),
    .cfg_fine(cfg_fine)
);

// File: tb/shadow_regfile_bench.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module shadow_regfile_bench;
    localparam int         PROG = 12;
    localparam logic [7:0] TRIM = 8'hF3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_stop = 1'b0;
    logic [3:0] bus_addr = '0, bus_raddr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ready, cfg_dac_en, cfg_dac_gain;
    logic [4:0] cfg_ilim, cfg_loop_gain;
    logic [2:0] cfg_coarse;
    logic [7:0] cfg_fine, cfg_dac_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    shadow_regfile #(.PROG_CYCLES(PROG), .TRIM_CODE(TRIM)) u_shadow_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_stop(bus_stop), .bus_raddr(bus_raddr),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .cfg_ilim(cfg_ilim),
        .cfg_coarse(cfg_coarse), .cfg_fine(cfg_fine), .cfg_dac_en(cfg_dac_en),
        .cfg_dac_gain(cfg_dac_gain), .cfg_loop_gain(cfg_loop_gain),
        .cfg_dac_code(cfg_dac_code)
    );

    // Monitor: compare read data against the queued expectation mid-cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                fails++;
                $display("FAIL %s read %0h: got %02h expected %02h", it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_raddr = a;
        sb_q.push_back('{a, e, tag});
        @(posedge clk); #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, e);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic stop();
        bus_stop = 1'b1;
        @(posedge clk); #1;
        bus_stop = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        do_reset();
        chk({7'd0, bus_ready}, 8'h00, "R1 ready low after reset");
        repeat (6) @(posedge clk); #1;
        chk({7'd0, bus_ready}, 8'h00, "R1 ready low during recall");
        @(posedge clk); #1;
        chk({7'd0, bus_ready}, 8'h01, "R1 ready after recall");

        // R2 and R8: defaults, identity and trim bytes
        rd_expect(4'h0, 8'h00, "R8 id");
        rd_expect(4'h1, 8'h03, "R2");
        rd_expect(4'h2, 8'h80, "R2");
        rd_expect(4'h3, 8'h90, "R2");
        rd_expect(4'h4, 8'h80, "R2");
        rd_expect(4'h5, 8'h00, "R2");
        rd_expect(4'h6, 8'h00, "R2");
        rd_expect(4'h7, TRIM,  "R8 trim");
        rd_expect(4'h8, 8'h00, "R2 ctrl");
        rd_expect(4'hC, 8'h00, "R8 unmapped");
        chk({3'd0, cfg_loop_gain}, 8'h10, "R10 loop gain default");
        chk(cfg_dac_code, 8'h80, "R11 dac code enabled");

        // R9: only bank bit writable in 08h
        wr(4'h8, 8'hFF);
        rd_expect(4'h8, 8'h80, "R9");

        // R3: working-only write, STOP starts nothing (R6)
        wr(4'h2, 8'h55);
        rd_expect(4'h2, 8'h55, "R3");
        chk(cfg_fine, 8'h55, "R3 fine field");
        stop();
        chk({7'd0, bus_ready}, 8'h01, "R6 no busy after volatile write");
        rd_expect(4'h8, 8'h80, "R6");

        // R10 and R11: field positions and DAC disable
        wr(4'h1, 8'hAD);
        chk({3'd0, cfg_ilim}, 8'h15, "R10 ilim");
        chk({5'd0, cfg_coarse}, 8'h05, "R10 coarse");
        wr(4'h3, 8'h10);
        chk({7'd0, cfg_dac_en}, 8'h00, "R10 dac enable");
        chk(cfg_dac_code, 8'h00, "R11 disabled code");
        wr(4'h4, 8'h3C);
        chk(cfg_dac_code, 8'h00, "R11 disabled code after 04h write");
        rd_expect(4'h4, 8'h3C, "R11 04h holds value");
        wr(4'h3, 8'hD3);
        chk({6'd0, cfg_dac_en, cfg_dac_gain}, 8'h03, "R10 enable and gain");
        chk({3'd0, cfg_loop_gain}, 8'h13, "R10 loop gain");
        chk(cfg_dac_code, 8'h3C, "R11 enabled code");

        // R8: writes to read-only and unmapped addresses
        wr(4'h0, 8'hAA);
        wr(4'h7, 8'h11);
        wr(4'h9, 8'h22);
        rd_expect(4'h0, 8'h00, "R8 id after write");
        rd_expect(4'h7, TRIM,  "R8 trim after write");
        rd_expect(4'h9, 8'h00, "R8 09h after write");

        // R4, R5, R7: non-volatile commit
        wr(4'h8, 8'h00);
        wr(4'h5, 8'hA5);
        rd_expect(4'h5, 8'h00, "R4 working copy unchanged");
        wr(4'h5, 8'h5A);
        stop();
        rd_expect(4'h8, 8'h01, "R5 busy first cycle");
        chk({7'd0, bus_ready}, 8'h00, "R5 ready low while busy");
        wr(4'h6, 8'h77);
        stop();
        repeat (PROG - 4) @(posedge clk); #1;
        rd_expect(4'h8, 8'h01, "R5 busy last cycle");
        rd_expect(4'h8, 8'h00, "R5 busy cleared");
        rd_expect(4'h5, 8'h5A, "R4 committed value");
        rd_expect(4'h6, 8'h00, "R7 write during busy ignored");
        stop();
        rd_expect(4'h8, 8'h00, "R6 stop without pending");

        // R12: recall after a second reset
        do_reset();
        repeat (8) @(posedge clk); #1;
        rd_expect(4'h5, 8'h5A, "R12 committed byte recalled");
        rd_expect(4'h2, 8'h80, "R12 volatile-only byte lost");
        rd_expect(4'h1, 8'h03, "R12 volatile-only byte lost");
        rd_expect(4'h8, 8'h00, "R12 bank bit reset");

        @(posedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule